// File: doc/BRIEF.md
# Dual-Channel Trigger and Transfer Flow Controller

This block sits between two upstream sample sources (channels A and B) and the downstream interpolation filters. For each channel it decides when to assert ready toward the source, what to forward downstream and when to hold the filters in reset. A transfer starts once the channel is enabled. Three things can also gate the start: a start-synchronization option that waits until both sources show valid data, a trigger built from two external pins and two internal trigger inputs, and a suspend control.

While a channel is running, the suspend control has two behaviours. Without flush it pauses the channel: ready drops, the filters are held, and the transfer continues from the same point once suspend clears. With flush it drains the sources by keeping ready high, throws the drained samples away and sends the raw register value instead. A per-channel raw enable replaces the source data with the raw value. A stop-synchronization option stops one channel when the other channel's transfer ends. A trigger event can also stop a running transfer.

Top module: `dual_xfer_ctrl`

## Requirements
- R1: After reset both ready outputs are 0, both output valids are 0 and both filter-hold bits are 1.
- R2: With start-sync off, no trigger source enabled and suspend clear, an enabled channel asserts ready after the second clock edge following enable. The first edge moves it to the wait state and the second edge moves it to run.
- R3: With start-sync on, a waiting channel does not start until both sources present valid in the same cycle. It starts at the next edge after that.
- R4: With any trigger source enabled (bits of `trig_en_i`: 3 logic-analyzer, 2 ADC, 1 pin 1, 0 pin 0), a waiting channel starts only one edge after a registered trigger event.
- R5: The pins pass through a two-flop synchronizer and then an edge detector. Each pin p has one bit in each of five condition fields of `trig_cond_i`: falling edge bit 8+p, rising edge bit 6+p, any edge bit 4+p, high level bit 2+p and low level bit p. From a pin change to ready rising takes four edges.
- R6: The ADC and logic-analyzer trigger inputs are level sensitive and registered once. A waiting channel starts on the second edge after one of them is raised.
- R7: In run, with suspend clear and raw disabled, ready is 1. A sample accepted at an edge appears on the output data with valid 1 after that edge.
- R8: Suspend with flush clear drops ready and holds the filters in the same cycle. The output valid is 0 after the next edge. Clearing suspend restores ready in the same cycle, without a restart.
- R9: Suspend with flush set keeps ready at 1 and releases the filter hold. After each edge the output carries the raw value with valid 1.
- R10: A set raw-enable bit (bit 0 for A, bit 1 for B) forces ready low on that channel. After each edge in run, that channel outputs its raw value with valid 1: channel A takes bits [15:0] of `raw_word_i` and channel B takes bits [31:16].
- R11: With stop-sync on, if one running channel loses its enable, the other channel stops at the same edge. It then holds ready at 0 until its own enable drops.
- R12: With `trig_stop_i` set, a trigger event seen by a running channel stops it at the next edge.
- R13: A channel whose enable is low returns to idle at the next edge, whatever state it was in, and its ready is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_a_i | input | 1 | Channel A enable; 1 while its source is active |
| chan_en_b_i | input | 1 | Channel B enable; 1 while its source is active |
| src_data_a_i | input | 16 | Channel A source sample |
| src_valid_a_i | input | 1 | Channel A source valid |
| src_ready_a_o | output | 1 | Channel A ready toward source |
| src_data_b_i | input | 16 | Channel B source sample |
| src_valid_b_i | input | 1 | Channel B source valid |
| src_ready_b_o | output | 1 | Channel B ready toward source |
| ext_trig_i | input | 2 | External trigger pins, asynchronous |
| adc_trig_i | input | 1 | Internal ADC trigger |
| la_trig_i | input | 1 | Internal logic-analyzer trigger |
| trig_en_i | input | 4 | Trigger source enables {LA, ADC, pin1, pin0} |
| trig_cond_i | input | 10 | Condition fields {fall, rise, any, high, low}, 2 bits each |
| trig_stop_i | input | 1 | A trigger event stops a running channel |
| start_sync_i | input | 1 | Wait for both sources valid before starting |
| stop_sync_i | input | 1 | One channel's end stops the other |
| suspend_i | input | 1 | Pause (or drain when flush set) |
| flush_i | input | 1 | Drain sources while suspended |
| raw_en_i | input | 2 | Raw data select {B, A} |
| raw_word_i | input | 32 | Raw values {B, A} |
| out_data_a_o | output | 16 | Channel A output sample |
| out_valid_a_o | output | 1 | Channel A output valid |
| out_data_b_o | output | 16 | Channel B output sample |
| out_valid_b_o | output | 1 | Channel B output valid |
| filt_hold_o | output | 2 | Filter reset/hold per channel {B, A} |

## Verification
Ready and filter hold follow the channel state and the suspend, flush and raw inputs in the same cycle, so the bench checks them a moment after it drives the inputs. A state change takes effect one edge after its condition and output data one edge after the accepted beat; the bench reads those values at the falling edge that follows. Trigger timing is counted edge by edge: a pin event needs four edges to reach ready (two synchronizer stages, the registered event, then the state update), while the ADC and logic-analyzer inputs need two. Each of these counts has a check on both sides of the edge where the result is due.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned NPIN = 2;
  localparam int unsigned DW = 16;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_RUN  = 2'd2,
    CH_STOP = 2'd3
  } ch_state_e;
endpackage

// File: rtl/xfer_trig.sv
module xfer_trig #(
  parameter int unsigned NPIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              adc_i,
  input  logic              la_i,
  input  logic [NPIN+1:0]   en_i,
  input  logic [5*NPIN-1:0] cond_i,
  output logic              hit_o,
  output logic              any_en_o
);
  localparam int unsigned FALL = 4 * NPIN;
  localparam int unsigned RISE = 3 * NPIN;
  localparam int unsigned ANY  = 2 * NPIN;
  localparam int unsigned HIGH = NPIN;

  logic [NPIN-1:0] s1_q, s2_q, s3_q, pin_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise, fall;
    assign rise = s2_q[p] & ~s3_q[p];
    assign fall = ~s2_q[p] & s3_q[p];
    assign pin_hit[p] = en_i[p] & ((cond_i[FALL+p] & fall) | (cond_i[RISE+p] & rise) |
                                   (cond_i[ANY+p] & (rise | fall)) |
                                   (cond_i[HIGH+p] & s2_q[p]) | (cond_i[p] & ~s2_q[p]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else hit_o <= (|pin_hit) | (en_i[NPIN] & adc_i) | (en_i[NPIN+1] & la_i);
  end

  assign any_en_o = |en_i;
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
  import xfer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] src_data_i,
  input  logic         src_valid_i,
  input  logic         peer_valid_i,
  input  logic         peer_end_i,
  input  logic         trig_ok_i,
  input  logic         trig_hit_i,
  input  logic         trig_stop_i,
  input  logic         start_sync_i,
  input  logic         stop_sync_i,
  input  logic         suspend_i,
  input  logic         flush_i,
  input  logic         raw_en_i,
  input  logic [W-1:0] raw_data_i,
  output logic         ready_o,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         hold_o,
  output logic         end_o
);
  ch_state_e st_q, st_d;
  logic run, go, drain;

  assign run   = (st_q == CH_RUN);
  assign drain = suspend_i & flush_i;
  assign go    = ~suspend_i & trig_ok_i & (~start_sync_i | (src_valid_i & peer_valid_i));

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = CH_IDLE;
    else begin
      unique case (st_q)
        CH_IDLE: st_d = CH_WAIT;
        CH_WAIT: if (go) st_d = CH_RUN;
        CH_RUN:  if ((stop_sync_i & peer_end_i) | (trig_stop_i & trig_hit_i)) st_d = CH_STOP;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CH_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (run) begin
        if (raw_en_i | drain) begin
          data_o  <= raw_data_i;
          valid_o <= 1'b1;
        end else if (!suspend_i) begin
          valid_o <= src_valid_i;
          if (src_valid_i) data_o <= src_data_i;
        end
      end
    end
  end

  assign ready_o = run & ~raw_en_i & (~suspend_i | flush_i);
  assign hold_o  = ~run | (suspend_i & ~flush_i);
  assign end_o   = run & ~en_i;
endmodule

// File: rtl/dual_xfer_ctrl.sv
module dual_xfer_ctrl
  import xfer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chan_en_a_i,
  input  logic          chan_en_b_i,
  input  logic [DW-1:0] src_data_a_i,
  input  logic          src_valid_a_i,
  output logic          src_ready_a_o,
  input  logic [DW-1:0] src_data_b_i,
  input  logic          src_valid_b_i,
  output logic          src_ready_b_o,
  input  logic [1:0]    ext_trig_i,
  input  logic          adc_trig_i,
  input  logic          la_trig_i,
  input  logic [3:0]    trig_en_i,
  input  logic [9:0]    trig_cond_i,
  input  logic          trig_stop_i,
  input  logic          start_sync_i,
  input  logic          stop_sync_i,
  input  logic          suspend_i,
  input  logic          flush_i,
  input  logic [1:0]    raw_en_i,
  input  logic [31:0]   raw_word_i,
  output logic [DW-1:0] out_data_a_o,
  output logic          out_valid_a_o,
  output logic [DW-1:0] out_data_b_o,
  output logic          out_valid_b_o,
  output logic [1:0]    filt_hold_o
);
  logic trig_hit, trig_any;
  logic [NCH-1:0] en, sv, rdy, ov, ended;
  logic [NCH-1:0][DW-1:0] sd, od, raw;

  assign en  = {chan_en_b_i, chan_en_a_i};
  assign sv  = {src_valid_b_i, src_valid_a_i};
  assign sd  = {src_data_b_i, src_data_a_i};
  assign raw = raw_word_i;

  xfer_trig #(.NPIN(NPIN)) u_trig (
    .clk_i, .rst_ni,
    .pin_i(ext_trig_i), .adc_i(adc_trig_i), .la_i(la_trig_i),
    .en_i(trig_en_i), .cond_i(trig_cond_i),
    .hit_o(trig_hit), .any_en_o(trig_any)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    xfer_chan #(.W(DW)) u_ch (
      .clk_i, .rst_ni,
      .en_i(en[c]), .src_data_i(sd[c]), .src_valid_i(sv[c]),
      .peer_valid_i(sv[NCH-1-c]), .peer_end_i(ended[NCH-1-c]),
      .trig_ok_i(~trig_any | trig_hit), .trig_hit_i(trig_hit), .trig_stop_i,
      .start_sync_i, .stop_sync_i, .suspend_i, .flush_i,
      .raw_en_i(raw_en_i[c]), .raw_data_i(raw[c]),
      .ready_o(rdy[c]), .data_o(od[c]), .valid_o(ov[c]),
      .hold_o(filt_hold_o[c]), .end_o(ended[c])
    );
  end

  assign src_ready_a_o = rdy[0];
  assign src_ready_b_o = rdy[1];
  assign out_data_a_o  = od[0];
  assign out_data_b_o  = od[1];
  assign out_valid_a_o = ov[0];
  assign out_valid_b_o = ov[1];
endmodule

// File: rtl/dual_xfer_ctrl_chk.sv
module dual_xfer_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        chan_en_a_i,
  input logic [15:0] src_data_a_i,
  input logic        src_valid_a_i,
  input logic        src_ready_a_o,
  input logic        src_ready_b_o,
  input logic        suspend_i,
  input logic        flush_i,
  input logic [1:0]  raw_en_i,
  input logic [31:0] raw_word_i,
  input logic [15:0] out_data_a_o,
  input logic        out_valid_a_o,
  input logic [1:0]  filt_hold_o
);
  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_a_o && src_valid_a_i && !suspend_i) |=>
      (out_valid_a_o && out_data_a_o == $past(src_data_a_i)));

  a_r8_pause_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !flush_i) |-> (!src_ready_a_o && !src_ready_b_o && filt_hold_o == 2'b11));

  a_r9_drain_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_a_o && suspend_i && flush_i) |=>
      (out_valid_a_o && out_data_a_o == $past(raw_word_i[15:0])));

  a_r10_raw_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_en_i[0] |-> !src_ready_a_o);

  a_r13_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_a_i |=> (!src_ready_a_o && filt_hold_o[0]));
endmodule

bind dual_xfer_ctrl dual_xfer_ctrl_chk u_chk (
  .clk_i, .rst_ni, .chan_en_a_i, .src_data_a_i, .src_valid_a_i, .src_ready_a_o,
  .src_ready_b_o, .suspend_i, .flush_i, .raw_en_i, .raw_word_i, .out_data_a_o,
  .out_valid_a_o, .filt_hold_o
);

// File: tb/sim_dual_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dual_xfer_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_a = 0, en_b = 0, sv_a = 0, sv_b = 0, la = 0, adc = 0, tstop = 0;
  logic ssync = 0, psync = 0, sus = 0, fl = 0;
  logic [15:0] sd_a = 0, sd_b = 0, od_a, od_b;
  logic [1:0] ext = 0, raw_en = 0, hold;
  logic [3:0] ten = 0;
  logic [9:0] tcond = 0;
  logic [31:0] raw = 0;
  logic rdy_a, rdy_b, ov_a, ov_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_xfer_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_a_i(en_a), .chan_en_b_i(en_b),
    .src_data_a_i(sd_a), .src_valid_a_i(sv_a), .src_ready_a_o(rdy_a),
    .src_data_b_i(sd_b), .src_valid_b_i(sv_b), .src_ready_b_o(rdy_b),
    .ext_trig_i(ext), .adc_trig_i(adc), .la_trig_i(la), .trig_en_i(ten),
    .trig_cond_i(tcond), .trig_stop_i(tstop), .start_sync_i(ssync), .stop_sync_i(psync),
    .suspend_i(sus), .flush_i(fl), .raw_en_i(raw_en), .raw_word_i(raw),
    .out_data_a_o(od_a), .out_valid_a_o(ov_a), .out_data_b_o(od_b), .out_valid_b_o(ov_b),
    .filt_hold_o(hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic exp_ready(input logic s, input logic f);
    return ~s | f;
  endfunction

  function automatic logic [16:0] exp_out(input logic s, input logic f, input logic v,
                                          input logic [15:0] d, input logic [15:0] r);
    if (s & f) return {1'b1, r};
    if (s) return {1'b0, 16'h0};
    return {v, d};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(2);
    chk("R1 ready", {rdy_b, rdy_a}, 0);
    chk("R1 valid", {ov_b, ov_a}, 0);
    chk("R1 hold", hold, 2'b11);
    rst_n = 1;
    tick();
    // R2 start after two edges
    en_a = 1; en_b = 1;
    tick();
    chk("R2 wait ready", {rdy_b, rdy_a}, 0);
    tick();
    chk("R2 run ready", {rdy_b, rdy_a}, 2'b11);
    chk("R2 hold released", hold, 2'b00);

    // R7 R8 R9 random mix
    for (int i = 0; i < 300; i++) begin
      logic [16:0] ea, eb;
      sus = ($urandom % 4) == 0;
      fl = $urandom % 2;
      sv_a = $urandom % 2; sv_b = $urandom % 2;
      sd_a = 16'($urandom); sd_b = 16'($urandom);
      raw = $urandom;
      #1;
      if (rdy_a !== exp_ready(sus, fl)) chk("R8 R9 random ready", rdy_a, exp_ready(sus, fl));
      ea = exp_out(sus, fl, sv_a, sd_a, raw[15:0]);
      eb = exp_out(sus, fl, sv_b, sd_b, raw[31:16]);
      tick();
      if (ea[16]) chk("R7 random out A", {ov_a, od_a}, ea);
      else chk("R7 random valid A", ov_a, 0);
      if (eb[16]) chk("R7 random out B", {ov_b, od_b}, eb);
      else chk("R7 random valid B", ov_b, 0);
    end

    // R8 pause and resume
    sv_a = 1; sd_a = 16'h1111; sus = 1; fl = 0;
    #1;
    chk("R8 pause ready", {rdy_b, rdy_a}, 0);
    chk("R8 pause hold", hold, 2'b11);
    tick();
    chk("R8 pause valid", ov_a, 0);
    sus = 0;
    #1;
    chk("R8 resume ready", {rdy_b, rdy_a}, 2'b11);
    tick();
    chk("R8 resume data", {ov_a, od_a}, {1'b1, 16'h1111});

    // R9 flush
    sus = 1; fl = 1; raw = 32'hBEEF_1234;
    #1;
    chk("R9 drain ready", {rdy_b, rdy_a}, 2'b11);
    chk("R9 hold", hold, 2'b00);
    tick();
    chk("R9 raw A", {ov_a, od_a}, {1'b1, 16'h1234});
    chk("R9 raw B", {ov_b, od_b}, {1'b1, 16'hBEEF});
    sus = 0; fl = 0;

    // R10 raw on A only
    raw_en = 2'b01; raw = 32'h5555_AAAA; sd_b = 16'h0B0B; sv_b = 1;
    #1;
    chk("R10 raw A ready", rdy_a, 0);
    chk("R10 B ready", rdy_b, 1);
    tick();
    chk("R10 raw A out", {ov_a, od_a}, {1'b1, 16'hAAAA});
    chk("R10 B pass", {ov_b, od_b}, {1'b1, 16'h0B0B});
    raw_en = 2'b10;
    tick();
    chk("R10 raw B out", {ov_b, od_b}, {1'b1, 16'h5555});
    raw_en = 0;

    // R11 stop sync
    psync = 1; en_a = 0;
    tick();
    chk("R11 A idle", rdy_a, 0);
    chk("R11 B stopped", rdy_b, 0);
    tick(2);
    chk("R11 B stays stopped", {hold[1], rdy_b}, 2'b10);
    en_b = 0; psync = 0;
    tick();
    // R13 restart from idle
    en_a = 1; en_b = 1;
    tick(2);
    chk("R13 restart", {rdy_b, rdy_a}, 2'b11);

    // R3 start sync
    en_a = 0; en_b = 0; tick();
    ssync = 1; sv_a = 1; sv_b = 0; en_a = 1; en_b = 1;
    tick(3);
    chk("R3 waits for both", {rdy_b, rdy_a}, 0);
    sv_b = 1;
    tick();
    chk("R3 both valid start", {rdy_b, rdy_a}, 2'b11);
    ssync = 0;

    // R4 R5 rising edge on pin 0
    en_a = 0; en_b = 0; tick();
    ten = 4'b0001; tcond = 10'h040; en_a = 1; en_b = 1;
    tick(2);
    chk("R4 no trigger no start", rdy_a, 0);
    ext[0] = 1;
    tick(3);
    chk("R5 rise not yet", rdy_a, 0);
    tick();
    chk("R5 rise start", {rdy_b, rdy_a}, 2'b11);

    // R5 low level on pin 1
    en_a = 0; en_b = 0; ext = 2'b10; ten = 4'b0010; tcond = 10'h002;
    tick(4);
    en_a = 1; en_b = 1;
    tick(2);
    chk("R5 high pin no start", rdy_a, 0);
    ext[1] = 0;
    tick(3);
    chk("R5 low not yet", rdy_a, 0);
    tick();
    chk("R5 low start", rdy_a, 1);

    // R6 ADC trigger
    en_a = 0; en_b = 0; tick();
    ten = 4'b0100; tcond = 0; en_a = 1; en_b = 1;
    tick();
    adc = 1;
    tick();
    chk("R6 adc not yet", rdy_a, 0);
    tick();
    chk("R6 adc start", rdy_a, 1);
    adc = 0;
    tick();

    // R12 trigger stop via LA
    ten = 4'b1000; tstop = 1; la = 1;
    tick();
    chk("R12 still running", rdy_a, 1);
    la = 0;
    tick();
    chk("R12 stopped", {rdy_b, rdy_a}, 0);
    chk("R12 hold", hold, 2'b11);

    // R13 from stopped
    en_a = 0;
    tick();
    en_a = 1; ten = 0; tstop = 0;
    tick(2);
    chk("R13 A restarts", rdy_a, 1);
    chk("R13 B still stopped", rdy_b, 0);
    finish_run();
  end
endmodule